// File: doc/BRIEF.md
# Run-Length Constrained Peak Corrector

This block sits behind a peak detector in a read channel. Once per bit cell, marked by a one-clock strobe, it receives one decision: whether the cell holds a peak, the polarity of that peak, and a magnitude. The magnitude is present even when no peak was found. The block checks the stream against two rules. Successive peaks must alternate in polarity. Each gap of non-peak cells between peaks must hold at least `d` and at most `k` cells. When a rule breaks, the block repairs the stream in the most likely way, using the magnitudes to decide. A weak extra peak is removed, and the strongest candidate in an over-long run is raised to a peak.

Decisions travel through a short delay line of `K_MAX+2` cells. A repair can therefore still reach a cell that arrived earlier, before that cell leaves as a serial data bit. Each repair type has its own enable. Each rule that breaks raises its own one-clock flag, whether or not its repair is enabled. With every enable low, the stream passes through unchanged after the fixed latency.

Top module: `rll_peak_fixer`

## Requirements
- R1: The corrected decision of a cell appears on `sd_bit` at the `K_MAX+2`-th strobe after the strobe that carried the cell in (9 strobes with the default `K_MAX=7`). `sd_bit` changes only at a strobe, so idle clocks between strobes do not move it. `sd_stb` pulses for one clock after each strobe.
- R2: An incoming peak with the same polarity as the last kept peak is an alternation error and raises `err_alt`.
- R3: When `en_alt_fix` is high, an alternation error is repaired by deleting the weaker of the two peaks. On equal magnitudes the incoming peak is the one deleted.
- R4: An incoming peak that follows the last kept peak with fewer than `cfg_dmin` non-peak cells between them is a spacing error and raises `err_dmin`.
- R5: When `en_dmin_fix` is high, a spacing error is repaired by the same weaker-peak deletion as in R3. A peak that breaks both rules at once causes a single deletion and raises both flags.
- R6: A run error is raised on `err_kmax` when, after a kept peak, a non-peak cell arrives while `cfg_kmax` non-peak cells have already followed that peak. A run raises it only once.
- R7: When `en_kmax_fix` is high, a run error is repaired by promoting to a peak the non-peak cell of largest magnitude in the current search window, which includes the cell that triggered the error. On equal magnitudes the earliest cell is chosen. The promoted cell takes the polarity opposite to the last kept peak and becomes the last kept peak. The next search starts with the triggering cell.
- R8: Each flag is a one-clock pulse in the clock after the strobe of the offending cell. It is raised even when the matching repair is disabled, and a disabled repair leaves the stream unchanged.
- R9: After reset, `sd_bit`, `sd_stb` and all flags are low and no peak history exists. The first peak after reset is never flagged.
- R10: `pk_neg` is 0 for a positive peak and 1 for a negative one. The configuration must satisfy 0 ≤ `cfg_dmin` ≤ `cfg_kmax` ≤ `K_MAX`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cell_stb | input | 1 | Bit-cell strobe, one clock wide |
| pk_det | input | 1 | Cell holds a detected peak |
| pk_neg | input | 1 | Peak polarity, 1 = negative |
| pk_mag | input | MAG_W | Sample magnitude of the cell |
| cfg_dmin | input | KW | Minimum non-peak cells between peaks |
| cfg_kmax | input | KW | Maximum non-peak cells between peaks |
| en_alt_fix | input | 1 | Enable alternation repair |
| en_dmin_fix | input | 1 | Enable spacing repair |
| en_kmax_fix | input | 1 | Enable run repair |
| sd_bit | output | 1 | Corrected serial data bit |
| sd_stb | output | 1 | Pulses one clock after each strobe |
| err_alt | output | 1 | Alternation error pulse |
| err_dmin | output | 1 | Spacing error pulse |
| err_kmax | output | 1 | Run error pulse |

## Verification
The error flags and `sd_stb` become valid one clock after the strobe that caused them. The bench drives each strobe at a falling edge and samples these outputs at the next falling edge, then checks again one clock later that each flag has dropped. A cell's own data bit appears only at the ninth strobe after the one that carried it. Each vector therefore drives eight data cells followed by nine flush cells with all repairs disabled, and bit i is read after strobe i+9, so repairs made late in the window still reach the compared bits. One directed run spaces strobes with zero to three idle clocks and checks the exact strobe at which a lone peak appears, and that the output holds between strobes.

// File: rtl/rlf_pkg.sv
package rlf_pkg;

   // What the incoming cell becomes after the checks of one strobe.
   typedef enum logic [1:0] {
      EV_GAP     = 2'd0,   // non-peak cell, no promotion
      EV_PEAK    = 2'd1,   // incoming peak kept
      EV_PRO_NEW = 2'd2,   // incoming non-peak cell promoted to a peak
      EV_PRO_OLD = 2'd3    // older cell in the window promoted to a peak
   } cell_evt_e;

endpackage

// File: rtl/rlf_decide.sv
module rlf_decide
   import rlf_pkg::*;
#(
   parameter int LEN   = 9,
   parameter int MAG_W = 6,
   parameter int KW    = 3,
   parameter int GW    = 4
) (
   input  logic             adv,
   input  logic             in_pk,
   input  logic             in_neg,
   input  logic [MAG_W-1:0] in_mag,
   input  logic             have_last,
   input  logic             last_neg,
   input  logic [MAG_W-1:0] last_mag,
   input  logic [GW-1:0]    gap,
   input  logic             cand_ok,
   input  logic [MAG_W-1:0] cand_mag,
   input  logic [KW-1:0]    cfg_d,
   input  logic [KW-1:0]    cfg_k,
   input  logic             en_alt,
   input  logic             en_dmin,
   input  logic             en_kmax,
   output logic             hit_alt,
   output logic             hit_dmin,
   output logic             hit_kmax,
   output logic             del_old,
   output cell_evt_e        evt
);

   logic [GW-1:0] d_ext;
   logic [GW-1:0] k_ext;
   logic          fix_pk;
   logic          new_wins;
   logic          drop_new;
   logic          kept;
   logic          pro_any;
   logic          pro_here;

   assign d_ext = GW'(cfg_d);
   assign k_ext = GW'(cfg_k);

   always_comb begin
      hit_alt  = adv & in_pk & have_last & (in_neg == last_neg);
      hit_dmin = adv & in_pk & have_last & (gap < d_ext);
      fix_pk   = (hit_alt & en_alt) | (hit_dmin & en_dmin);
      // ties keep the older peak
      new_wins = in_mag > last_mag;
      drop_new = fix_pk & ~new_wins;
      kept     = in_pk & ~drop_new;
      del_old  = kept & fix_pk & (gap < GW'(LEN));
      hit_kmax = adv & ~kept & have_last & (gap == k_ext);
      pro_any  = hit_kmax & en_kmax;
      // ties keep the earlier candidate
      pro_here = ~cand_ok | (in_mag > cand_mag);
      if (pro_any)
         evt = pro_here ? EV_PRO_NEW : EV_PRO_OLD;
      else if (kept)
         evt = EV_PEAK;
      else
         evt = EV_GAP;
   end

endmodule

// File: rtl/rlf_track.sv
module rlf_track
   import rlf_pkg::*;
#(
   parameter int LEN   = 9,
   parameter int MAG_W = 6,
   parameter int KW    = 3,
   parameter int GW    = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   input  cell_evt_e        evt,
   input  logic             in_neg,
   input  logic [MAG_W-1:0] in_mag,
   input  logic [KW-1:0]    cfg_k,
   output logic             have_last,
   output logic             last_neg,
   output logic [MAG_W-1:0] last_mag,
   output logic [GW-1:0]    gap,
   output logic             cand_ok,
   output logic [GW-1:0]    cand_idx,
   output logic [MAG_W-1:0] cand_mag
);

   localparam logic [GW-1:0] GAP_SAT  = GW'(LEN);
   localparam logic [GW-1:0] IDX_LAST = GW'(LEN - 1);

   logic [GW-1:0] gap_inc;
   logic [GW-1:0] k_ext;

   assign gap_inc = (gap == GAP_SAT) ? GAP_SAT : gap + GW'(1);
   assign k_ext   = GW'(cfg_k);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         have_last <= 1'b0;
         last_neg  <= 1'b0;
         last_mag  <= '0;
         gap       <= '0;
         cand_ok   <= 1'b0;
         cand_idx  <= '0;
         cand_mag  <= '0;
      end else if (adv) begin
         unique case (evt)
            EV_PEAK: begin
               have_last <= 1'b1;
               last_neg  <= in_neg;
               last_mag  <= in_mag;
               gap       <= '0;
               cand_ok   <= 1'b0;
            end
            EV_PRO_NEW: begin
               have_last <= 1'b1;
               last_neg  <= ~last_neg;
               last_mag  <= in_mag;
               gap       <= '0;
               cand_ok   <= 1'b0;
            end
            EV_PRO_OLD: begin
               last_neg  <= ~last_neg;
               last_mag  <= cand_mag;
               gap       <= cand_idx + GW'(1);
               cand_ok   <= 1'b1;
               cand_idx  <= '0;
               cand_mag  <= in_mag;
            end
            default: begin
               gap <= gap_inc;
               if (!cand_ok || (in_mag > cand_mag)) begin
                  cand_ok  <= 1'b1;
                  cand_idx <= '0;
                  cand_mag <= in_mag;
               end else if (cand_idx >= IDX_LAST) begin
                  cand_ok  <= 1'b0;
               end else begin
                  cand_idx <= cand_idx + GW'(1);
               end
            end
         endcase
      end
   end

   // R7: after an older cell is promoted, the run restarts no longer than k
   a_r7_run_rebased: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && evt == EV_PRO_OLD) |=> (gap <= $past(k_ext)));

   // R7: a promoted incoming cell is the newest peak
   a_r7_new_promoted: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && evt == EV_PRO_NEW) |=> (gap == '0 && have_last));

   // R9: a candidate is always inside the window
   a_r9_cand_in_window: assert property (@(posedge clk) disable iff (!rst_n)
      cand_ok |-> (cand_idx <= IDX_LAST));

endmodule

// File: rtl/rlf_delay.sv
module rlf_delay #(
   parameter int LEN = 9,
   parameter int GW  = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          adv,
   input  logic          in_bit,
   input  logic          del_en,
   input  logic [GW-1:0] del_idx,
   input  logic          pro_en,
   input  logic [GW-1:0] pro_idx,
   output logic          out_bit
);

   if (LEN < 3) begin : g_bad_len
      $error("rlf_delay: LEN must be at least 3");
   end

   logic [LEN-1:0] win;
   logic [LEN-1:0] fixed;

   for (genvar i = 0; i < LEN; i++) begin : g_cell
      assign fixed[i] = (win[i] & ~(del_en && (del_idx == GW'(i))))
                      | (pro_en && (pro_idx == GW'(i)));
      if (i == 0) begin : g_head
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   win[i] <= 1'b0;
            else if (adv) win[i] <= in_bit;
         end
      end else begin : g_body
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   win[i] <= 1'b0;
            else if (adv) win[i] <= fixed[i-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   out_bit <= 1'b0;
      else if (adv) out_bit <= fixed[LEN-1];
   end

   // R3: a deletion always lands on a stored peak
   a_r3_del_on_peak: assert property (@(posedge clk) disable iff (!rst_n)
      del_en |-> ((del_idx < GW'(LEN)) && win[del_idx]));

   // R7: a promotion always lands on a stored non-peak cell
   a_r7_pro_on_gap: assert property (@(posedge clk) disable iff (!rst_n)
      pro_en |-> ((pro_idx < GW'(LEN)) && !win[pro_idx]));

   // R5: at most one repair per strobe
   a_r5_single_fix: assert property (@(posedge clk) disable iff (!rst_n)
      !(del_en && pro_en));

endmodule

// File: rtl/rll_peak_fixer.sv
module rll_peak_fixer
   import rlf_pkg::*;
#(
   parameter  int K_MAX = 7,
   parameter  int MAG_W = 6,
   localparam int LEN   = K_MAX + 2,
   localparam int KW    = $clog2(K_MAX + 1),
   localparam int GW    = $clog2(LEN + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cell_stb,
   input  logic             pk_det,
   input  logic             pk_neg,
   input  logic [MAG_W-1:0] pk_mag,
   input  logic [KW-1:0]    cfg_dmin,
   input  logic [KW-1:0]    cfg_kmax,
   input  logic             en_alt_fix,
   input  logic             en_dmin_fix,
   input  logic             en_kmax_fix,
   output logic             sd_bit,
   output logic             sd_stb,
   output logic             err_alt,
   output logic             err_dmin,
   output logic             err_kmax
);

   if (K_MAX < 1 || MAG_W < 1) begin : g_bad_cfg
      $error("rll_peak_fixer: K_MAX and MAG_W must be positive");
   end

   logic             have_last;
   logic             last_neg;
   logic [MAG_W-1:0] last_mag;
   logic [GW-1:0]    gap;
   logic             cand_ok;
   logic [GW-1:0]    cand_idx;
   logic [MAG_W-1:0] cand_mag;
   logic             hit_alt;
   logic             hit_dmin;
   logic             hit_kmax;
   logic             del_old;
   cell_evt_e        evt;
   logic             head_bit;
   logic             pro_old;

   rlf_decide #(.LEN(LEN), .MAG_W(MAG_W), .KW(KW), .GW(GW)) u_decide (
      .adv      (cell_stb),
      .in_pk    (pk_det),
      .in_neg   (pk_neg),
      .in_mag   (pk_mag),
      .have_last(have_last),
      .last_neg (last_neg),
      .last_mag (last_mag),
      .gap      (gap),
      .cand_ok  (cand_ok),
      .cand_mag (cand_mag),
      .cfg_d    (cfg_dmin),
      .cfg_k    (cfg_kmax),
      .en_alt   (en_alt_fix),
      .en_dmin  (en_dmin_fix),
      .en_kmax  (en_kmax_fix),
      .hit_alt  (hit_alt),
      .hit_dmin (hit_dmin),
      .hit_kmax (hit_kmax),
      .del_old  (del_old),
      .evt      (evt)
   );

   rlf_track #(.LEN(LEN), .MAG_W(MAG_W), .KW(KW), .GW(GW)) u_track (
      .clk      (clk),
      .rst_n    (rst_n),
      .adv      (cell_stb),
      .evt      (evt),
      .in_neg   (pk_neg),
      .in_mag   (pk_mag),
      .cfg_k    (cfg_kmax),
      .have_last(have_last),
      .last_neg (last_neg),
      .last_mag (last_mag),
      .gap      (gap),
      .cand_ok  (cand_ok),
      .cand_idx (cand_idx),
      .cand_mag (cand_mag)
   );

   assign head_bit = (evt == EV_PEAK) || (evt == EV_PRO_NEW);
   assign pro_old  = cell_stb && (evt == EV_PRO_OLD);

   rlf_delay #(.LEN(LEN), .GW(GW)) u_delay (
      .clk    (clk),
      .rst_n  (rst_n),
      .adv    (cell_stb),
      .in_bit (head_bit),
      .del_en (del_old),
      .del_idx(gap),
      .pro_en (pro_old),
      .pro_idx(cand_idx),
      .out_bit(sd_bit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sd_stb   <= 1'b0;
         err_alt  <= 1'b0;
         err_dmin <= 1'b0;
         err_kmax <= 1'b0;
      end else begin
         sd_stb   <= cell_stb;
         err_alt  <= hit_alt;
         err_dmin <= hit_dmin;
         err_kmax <= hit_kmax;
      end
   end

   // R8: a flag only ever follows a strobe
   a_r8_flag_after_stb: assert property (@(posedge clk) disable iff (!rst_n)
      (err_alt || err_dmin || err_kmax) |-> $past(cell_stb));

   // R1: the serial bit holds between strobes
   a_r1_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(cell_stb) |-> $stable(sd_bit));

endmodule

// File: tb/rll_peak_fixer_tb.sv
`timescale 1ns/1ps
module rll_peak_fixer_tb;

   localparam int NV = 12;
   localparam int LAT = 9;

   // cells c7..c0, byte = {peak, negative, magnitude[5:0]}
   localparam logic [63:0] V_CELL [NV] = '{
      64'hD4029402D4020294,  // 0  clean stream
      64'h010101DE018A019E,  // 1  alt, weaker new dropped
      64'h010101DE019E018A,  // 2  alt, weaker old deleted
      64'h010101DE019E018A,  // 3  alt, repair disabled
      64'h0101D90101CA019E,  // 4  dmin, new dropped
      64'h0101990101DE018A,  // 5  dmin, old deleted
      64'h019402040509039E,  // 6  kmax, older cell promoted
      64'h019402040509039E,  // 7  kmax disabled
      64'h019401080203029E,  // 8  kmax, incoming promoted
      64'h019401D401940194,  // 9  alt tie
      64'h01940101D4018A9E,  // 10 alt and dmin together
      64'h010194050505059E   // 11 kmax tie, earliest promoted
   };
   localparam logic [2:0] V_D   [NV] = '{3'd1,3'd1,3'd1,3'd1,3'd2,3'd2,3'd1,3'd1,3'd1,3'd1,3'd2,3'd1};
   localparam logic [2:0] V_K   [NV] = '{3'd3,3'd3,3'd3,3'd3,3'd4,3'd4,3'd3,3'd3,3'd3,3'd3,3'd4,3'd3};
   // {alt, dmin, kmax} enables
   localparam logic [2:0] V_EN  [NV] = '{3'b111,3'b111,3'b111,3'b011,3'b111,3'b111,
                                         3'b111,3'b110,3'b111,3'b111,3'b111,3'b111};
   localparam logic [7:0] V_OUT [NV] = '{8'hA9,8'h11,8'h14,8'h15,8'h21,8'h24,
                                         8'h45,8'h01,8'h51,8'h51,8'h49,8'h23};
   // expected flag counts {alt, dmin, kmax}
   localparam logic [2:0] V_FLG [NV] = '{3'b000,3'b100,3'b100,3'b100,3'b010,3'b010,
                                         3'b001,3'b101,3'b001,3'b100,3'b110,3'b001};

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cell_stb = 1'b0;
   logic       pk_det = 1'b0;
   logic       pk_neg = 1'b0;
   logic [5:0] pk_mag = '0;
   logic [2:0] cfg_dmin = 3'd1;
   logic [2:0] cfg_kmax = 3'd3;
   logic       en_alt_fix = 1'b0;
   logic       en_dmin_fix = 1'b0;
   logic       en_kmax_fix = 1'b0;
   logic       sd_bit, sd_stb, err_alt, err_dmin, err_kmax;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   logic s_out, s_stb, s_alt, s_dmin, s_kmax, s_hold;

   always #4 clk = ~clk;

   rll_peak_fixer u_dut (
      .clk(clk), .rst_n(rst_n), .cell_stb(cell_stb), .pk_det(pk_det),
      .pk_neg(pk_neg), .pk_mag(pk_mag), .cfg_dmin(cfg_dmin), .cfg_kmax(cfg_kmax),
      .en_alt_fix(en_alt_fix), .en_dmin_fix(en_dmin_fix), .en_kmax_fix(en_kmax_fix),
      .sd_bit(sd_bit), .sd_stb(sd_stb), .err_alt(err_alt), .err_dmin(err_dmin),
      .err_kmax(err_kmax)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      cell_stb = 1'b0;
      rst_n    = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   // one cell: strobe for one clock, sample one clock later, then idle clocks
   task automatic send(input logic [7:0] c, input int idle);
      @(negedge clk);
      cell_stb = 1'b1;
      pk_det   = c[7];
      pk_neg   = c[6];
      pk_mag   = c[5:0];
      @(negedge clk);
      cell_stb = 1'b0;
      s_out  = sd_bit;
      s_stb  = sd_stb;
      s_alt  = err_alt;
      s_dmin = err_dmin;
      s_kmax = err_kmax;
      repeat (idle) @(negedge clk);
      s_hold = sd_bit;
   endtask

   function automatic string vec_req(input int v);
      case (v)
         0:  return "R1 R10 clean stream";
         1:  return "R2 R3 alt drop new";
         2:  return "R3 alt delete old";
         3:  return "R8 R2 alt disabled";
         4:  return "R4 R5 dmin drop new";
         5:  return "R5 dmin delete old";
         6:  return "R6 R7 kmax promote old";
         7:  return "R8 R6 kmax disabled";
         8:  return "R7 kmax promote new";
         9:  return "R3 alt tie";
         10: return "R5 alt+dmin single fix";
         default: return "R7 kmax tie earliest";
      endcase
   endfunction

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      // R9: reset state
      do_reset();
      check("R9 sd_bit after reset", int'(sd_bit), 0);
      check("R9 sd_stb after reset", int'(sd_stb), 0);
      check("R9 flags after reset", int'({err_alt, err_dmin, err_kmax}), 0);

      // vector table
      for (int v = 0; v < NV; v++) begin
         logic [7:0] got;
         int n_a, n_d, n_k;
         cfg_dmin = V_D[v];
         cfg_kmax = V_K[v];
         {en_alt_fix, en_dmin_fix, en_kmax_fix} = V_EN[v];
         do_reset();
         got = '0; n_a = 0; n_d = 0; n_k = 0;
         for (int s = 0; s < 8 + LAT; s++) begin
            if (s == 8) {en_alt_fix, en_dmin_fix, en_kmax_fix} = 3'b000;
            send((s < 8) ? V_CELL[v][s*8 +: 8] : 8'h00, s % 2);
            if (s < 8) begin
               n_a += int'(s_alt);
               n_d += int'(s_dmin);
               n_k += int'(s_kmax);
            end
            if (s >= LAT) got[s-LAT] = s_out;
         end
         check({vec_req(v), " data"}, int'(got), int'(V_OUT[v]));
         check({vec_req(v), " flags R8"}, n_a*100 + n_d*10 + n_k,
               int'(V_FLG[v][2])*100 + int'(V_FLG[v][1])*10 + int'(V_FLG[v][0]));
      end

      // R1: latency with irregular strobe spacing, output held while idle
      cfg_dmin = 3'd1; cfg_kmax = 3'd3;
      {en_alt_fix, en_dmin_fix, en_kmax_fix} = 3'b000;
      do_reset();
      for (int j = 0; j <= LAT; j++) begin
         send((j == 0) ? 8'h94 : 8'h00, j % 4);
         check($sformatf("R1 sd_bit after strobe %0d", j), int'(s_out), (j == LAT) ? 1 : 0);
         check("R1 sd_stb pulse", int'(s_stb), 1);
         check("R1 hold between strobes", int'(s_hold), int'(s_out));
      end

      // R8 and R9: first peak not flagged, flag is one clock wide
      do_reset();
      send(8'h94, 0);
      check("R9 first peak unflagged", int'({s_alt, s_dmin, s_kmax}), 0);
      send(8'h8A, 0);
      check("R8 R2 alt flag raised while disabled", int'(s_alt), 1);
      @(negedge clk);
      check("R8 flag drops after one clock", int'(err_alt), 0);
      check("R8 sd_stb drops after one clock", int'(sd_stb), 0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule